// File: doc/BRIEF.md
# System Control Register Bank

A memory-mapped bank of board-level status and control registers on a plain 32-bit write/read bus addressed by byte offset within a 4 KB window. Software uses it to read a fixed identity word and drive indicator LEDs. It keeps scratch flags in two kinds: one set is wiped by a soft reset, the other survives it. A key-protected lock guards the reset-control register, and a write to that register can ask the system for a reset.

Several board generations share the bank. The generation is decoded from bits 27:16 of the identity parameter: 0x100 is the legacy board, 0x140 the evaluation board, 0x178 and 0x182 the "plus" boards, 0x190 the express board, and any other code is treated as "other". The generation decides three things: which bits of the display-control register can be written, which bit of reset control fires a reset request, and where the write-protect pin appears in the card-status word. A free-running counter gives software a 24 MHz time base derived from the bus clock.

Writes take effect at the clock edge on which `bus_wr` is high. Reads are combinational from `bus_addr` and have no side effects. `por` clears every register. `rst` is the soft reset and clears everything except the non-volatile flags and the time base.

Top module: `sysctl_regs`

## Requirements
- R1: Offset 0x000 returns the identity parameter and offset 0x044 always returns 1. Any offset not listed in these requirements (for example 0x034, 0x03C and 0x100) reads 0, and a write to it changes no register.
- R2: Offset 0x008 is a 32-bit LED register that returns the last value written to it.
- R3: A write to offset 0x020 stores 0xA05F when the written word equals 0x0000A05F. Any other written word stores its bits 14:0 with bit 15 cleared. The stored 16-bit value is read back zero-extended. The bank is unlocked only while it holds 0xA05F.
- R4: A write to reset control at 0x040 updates it only while the bank is unlocked; at other times it is ignored. On the legacy and plus boards the register reads back the last accepted value. On every other board it reads 0 and ignores writes.
- R5: An accepted reset-control write asks for a reset when bit 8 of the data is set (legacy) or bit 2 is set (plus). `rst_req` is high for exactly the one cycle after that write edge.
- R6: A write to 0x030 ORs the data into the volatile flags, and a write to 0x034 clears each flag whose data bit is 1. Reading 0x030 returns the flags.
- R7: Offsets 0x038 (set, and read) and 0x03C (clear) do the same for the non-volatile flags. These flags keep their value through `rst` and are cleared only by `por`.
- R8: `rst` clears the LEDs, lock, flags, reset level and mux select, and returns display control to its reset value.
- R9: Display control at 0x050 resets to 0x1F00, except on the express board, where it always reads 0. On legacy and evaluation boards bits 13:8 are read-only and all other bits are writable. On plus boards only bit 7 is writable.
- R10: On the legacy board, a write to display control loads data bits 1:0 into `mux_sel`. On all other boards `mux_sel` stays 0.
- R11: Card status at 0x048 shows `card_in` in bit 0 and `wp_in` in bit 2 on legacy and evaluation boards, or in bit 1 on later boards. The pins are registered, so they appear one cycle after they change.
- R12: Offset 0x05C returns a counter that advances by exactly TICK_HZ counts per CLK_HZ clock cycles (24 per 125 cycles by default).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| por | input | 1 | Power-on reset, synchronous, active high; clears all state |
| rst | input | 1 | Soft reset, synchronous, active high |
| bus_wr | input | 1 | Write strobe for the current address |
| bus_addr | input | 12 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| card_in | input | 1 | Card-present pin |
| wp_in | input | 1 | Card write-protect pin |
| rst_req | output | 1 | One-cycle reset request |
| mux_sel | output | 2 | Display format mux select |

## Verification
A lock register holding the wrong value shows up at the next reset-control write. Either the write is dropped and reads back stale, or a reset request pulses where none was due, one cycle after that write edge. A flag register that takes a bad update shows the wrong word on the very next read of its offset. Losing the non-volatile flags in a soft reset is visible on the first read after `rst` falls. A time base whose accumulator is wrong reads as a wrong count delta over any 125-cycle window. Variant decode errors move bits within the display-control, card-status and reset-control read data, so three instances built for different boards are compared under identical stimulus.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

    typedef enum logic [2:0] {
        VAR_LEGACY,
        VAR_EVAL,
        VAR_PLUS,
        VAR_EXPRESS,
        VAR_OTHER
    } board_t;

    typedef struct packed {
        logic        wr;
        logic [11:0] addr;
        logic [31:0] data;
    } bus_wr_t;

    localparam logic [11:0] OFS_ID     = 12'h000;
    localparam logic [11:0] OFS_LED    = 12'h008;
    localparam logic [11:0] OFS_LOCK   = 12'h020;
    localparam logic [11:0] OFS_FSET   = 12'h030;
    localparam logic [11:0] OFS_FCLR   = 12'h034;
    localparam logic [11:0] OFS_NVSET  = 12'h038;
    localparam logic [11:0] OFS_NVCLR  = 12'h03C;
    localparam logic [11:0] OFS_RSTCTL = 12'h040;
    localparam logic [11:0] OFS_PCI    = 12'h044;
    localparam logic [11:0] OFS_CARD   = 12'h048;
    localparam logic [11:0] OFS_DISP   = 12'h050;
    localparam logic [11:0] OFS_TICK   = 12'h05C;

    localparam logic [31:0] UNLOCK_KEY = 32'h0000_A05F;

    function automatic board_t board_of(input logic [31:0] id);
        case (id[27:16])
            12'h100:          return VAR_LEGACY;
            12'h140:          return VAR_EVAL;
            12'h178, 12'h182: return VAR_PLUS;
            12'h190:          return VAR_EXPRESS;
            default:          return VAR_OTHER;
        endcase
    endfunction

    function automatic bit has_rstctl(input board_t b);
        return (b == VAR_LEGACY) || (b == VAR_PLUS);
    endfunction

    function automatic int trig_bit(input board_t b);
        return (b == VAR_LEGACY) ? 8 : 2;
    endfunction

    function automatic int wp_bit(input board_t b);
        return ((b == VAR_LEGACY) || (b == VAR_EVAL)) ? 2 : 1;
    endfunction

    function automatic logic [31:0] disp_wmask(input board_t b);
        case (b)
            VAR_LEGACY, VAR_EVAL: return ~32'h0000_3F00;
            VAR_PLUS:             return 32'h0000_0080;
            default:              return 32'h0;
        endcase
    endfunction

endpackage

// File: rtl/sysctl_lockreset.sv
module sysctl_lockreset
    import sysctl_pkg::*;
#(
    parameter board_t BOARD = VAR_LEGACY
) (
    input  logic        clk,
    input  logic        por,
    input  logic        rst,
    input  bus_wr_t     wr,
    output logic [15:0] lock_val,
    output logic [31:0] level,
    output logic        unlocked,
    output logic        req
);
    localparam bit HAS = has_rstctl(BOARD);
    localparam int TB  = trig_bit(BOARD);

    logic accept;

    assign unlocked = (lock_val == UNLOCK_KEY[15:0]);
    assign accept   = HAS && wr.wr && (wr.addr == OFS_RSTCTL) && unlocked;

    always_ff @(posedge clk) begin
        if (por || rst) begin
            lock_val <= '0;
            level    <= '0;
            req      <= 1'b0;
        end else begin
            req <= accept && wr.data[TB];
            if (wr.wr && wr.addr == OFS_LOCK) begin
                lock_val <= (wr.data == UNLOCK_KEY) ? UNLOCK_KEY[15:0]
                                                    : {1'b0, wr.data[14:0]};
            end
            if (accept) begin
                level <= wr.data;
            end
        end
    end
endmodule

// File: rtl/sysctl_setclr.sv
module sysctl_setclr #(
    parameter int W          = 32,
    parameter bit SOFT_CLEAR = 1'b1
) (
    input  logic         clk,
    input  logic         por,
    input  logic         rst,
    input  logic         set_en,
    input  logic         clr_en,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (por || (SOFT_CLEAR && rst)) begin
            q <= '0;
        end else if (set_en) begin
            q <= q | d;
        end else if (clr_en) begin
            q <= q & ~d;
        end
    end
endmodule

// File: rtl/sysctl_display.sv
module sysctl_display
    import sysctl_pkg::*;
#(
    parameter board_t BOARD = VAR_LEGACY
) (
    input  logic        clk,
    input  logic        por,
    input  logic        rst,
    input  bus_wr_t     wr,
    output logic [31:0] disp,
    output logic [1:0]  mux_sel
);
    localparam logic [31:0] RST_VAL = (BOARD == VAR_EXPRESS) ? 32'h0 : 32'h0000_1F00;
    localparam logic [31:0] WMASK   = disp_wmask(BOARD);
    localparam bit          HAS_MUX = (BOARD == VAR_LEGACY);

    logic hit;
    assign hit = wr.wr && (wr.addr == OFS_DISP);

    always_ff @(posedge clk) begin
        if (por || rst) begin
            disp    <= RST_VAL;
            mux_sel <= 2'b00;
        end else if (hit) begin
            disp <= (disp & ~WMASK) | (wr.data & WMASK);
            if (HAS_MUX) begin
                mux_sel <= wr.data[1:0];
            end
        end
    end
endmodule

// File: rtl/sysctl_tick.sv
module sysctl_tick #(
    parameter int CLK_HZ  = 125_000_000,
    parameter int TICK_HZ = 24_000_000,
    parameter int CNT_W   = 32
) (
    input  logic             clk,
    input  logic             por,
    output logic [CNT_W-1:0] count
);
    localparam int          AW    = $clog2(CLK_HZ) + 1;
    localparam logic [AW-1:0] STEP  = AW'(TICK_HZ);
    localparam logic [AW-1:0] LIMIT = AW'(CLK_HZ);

    logic [AW-1:0] acc;
    logic [AW-1:0] sum;

    assign sum = acc + STEP;

    always_ff @(posedge clk) begin
        if (por) begin
            acc   <= '0;
            count <= '0;
        end else if (sum >= LIMIT) begin
            acc   <= sum - LIMIT;
            count <= count + 1'b1;
        end else begin
            acc <= sum;
        end
    end
endmodule

// File: rtl/sysctl_regs.sv
module sysctl_regs
    import sysctl_pkg::*;
#(
    parameter logic [31:0] SYS_ID  = 32'h4100_5000,
    parameter int          CLK_HZ  = 125_000_000,
    parameter int          TICK_HZ = 24_000_000
) (
    input  logic        clk,
    input  logic        por,
    input  logic        rst,
    input  logic        bus_wr,
    input  logic [11:0] bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    input  logic        card_in,
    input  logic        wp_in,
    output logic        rst_req,
    output logic [1:0]  mux_sel
);
    localparam board_t BOARD = board_of(SYS_ID);
    localparam int     WPB   = wp_bit(BOARD);

    bus_wr_t     wr;
    logic [31:0] led_q;
    logic [15:0] lock_val;
    logic [31:0] level;
    logic        lock_open;
    logic [31:0] disp;
    logic [31:0] tick_cnt;
    logic        card_q, wp_q;
    logic [31:0] card_word;
    logic [1:0][31:0] flag_q;
    logic [31:0] flags_q, nvflags_q;

    assign wr = '{wr: bus_wr, addr: bus_addr, data: bus_wdata};

    always_ff @(posedge clk) begin
        if (por || rst) begin
            led_q  <= '0;
            card_q <= 1'b0;
            wp_q   <= 1'b0;
        end else begin
            card_q <= card_in;
            wp_q   <= wp_in;
            if (bus_wr && bus_addr == OFS_LED) begin
                led_q <= bus_wdata;
            end
        end
    end

    sysctl_lockreset #(.BOARD(BOARD)) u_lock (
        .clk(clk), .por(por), .rst(rst), .wr(wr),
        .lock_val(lock_val), .level(level), .unlocked(lock_open), .req(rst_req)
    );

    for (genvar g = 0; g < 2; g++) begin : g_flags
        localparam logic [11:0] SET_A = (g == 0) ? OFS_FSET : OFS_NVSET;
        localparam logic [11:0] CLR_A = (g == 0) ? OFS_FCLR : OFS_NVCLR;
        sysctl_setclr #(.W(32), .SOFT_CLEAR(g == 0)) u_reg (
            .clk(clk), .por(por), .rst(rst),
            .set_en(bus_wr && bus_addr == SET_A),
            .clr_en(bus_wr && bus_addr == CLR_A),
            .d(bus_wdata), .q(flag_q[g])
        );
    end

    assign flags_q   = flag_q[0];
    assign nvflags_q = flag_q[1];

    sysctl_display #(.BOARD(BOARD)) u_disp (
        .clk(clk), .por(por), .rst(rst), .wr(wr),
        .disp(disp), .mux_sel(mux_sel)
    );

    sysctl_tick #(.CLK_HZ(CLK_HZ), .TICK_HZ(TICK_HZ), .CNT_W(32)) u_tick (
        .clk(clk), .por(por), .count(tick_cnt)
    );

    always_comb begin
        card_word      = '0;
        card_word[0]   = card_q;
        card_word[WPB] = wp_q;
    end

    always_comb begin
        case (bus_addr)
            OFS_ID:     bus_rdata = SYS_ID;
            OFS_LED:    bus_rdata = led_q;
            OFS_LOCK:   bus_rdata = {16'h0, lock_val};
            OFS_FSET:   bus_rdata = flags_q;
            OFS_NVSET:  bus_rdata = nvflags_q;
            OFS_RSTCTL: bus_rdata = level;
            OFS_PCI:    bus_rdata = 32'h1;
            OFS_CARD:   bus_rdata = card_word;
            OFS_DISP:   bus_rdata = disp;
            OFS_TICK:   bus_rdata = tick_cnt;
            default:    bus_rdata = 32'h0;
        endcase
    end
endmodule

// File: rtl/sysctl_regs_chk.sv
module sysctl_regs_chk
    import sysctl_pkg::*;
(
    input logic        clk,
    input logic        por,
    input logic        rst,
    input logic        bus_wr,
    input logic [11:0] bus_addr,
    input logic [31:0] bus_wdata,
    input logic [31:0] bus_rdata,
    input logic        unlocked,
    input logic        rst_req,
    input logic [31:0] flags,
    input logic [31:0] nvflags,
    input logic [1:0]  mux_sel
);
    assert_const_read_R1: assert property (@(posedge clk) disable iff (por || rst)
        (bus_addr == OFS_PCI) |-> (bus_rdata == 32'h1));

    assert_bad_key_locks_R3: assert property (@(posedge clk) disable iff (por || rst)
        (bus_wr && bus_addr == OFS_LOCK && bus_wdata != UNLOCK_KEY) |=> !unlocked);

    assert_req_needs_unlock_R4: assert property (@(posedge clk) disable iff (por || rst)
        rst_req |-> $past(bus_wr && bus_addr == OFS_RSTCTL && unlocked));

    assert_flag_set_R6: assert property (@(posedge clk) disable iff (por || rst)
        (bus_wr && bus_addr == OFS_FSET) |=> ((flags & $past(bus_wdata)) == $past(bus_wdata)));

    assert_nv_keep_R7: assert property (@(posedge clk) disable iff (por)
        (rst && !bus_wr) |=> $stable(nvflags));

    assert_mux_hold_R10: assert property (@(posedge clk) disable iff (por || rst)
        !(bus_wr && bus_addr == OFS_DISP) |=> $stable(mux_sel));
endmodule

bind sysctl_regs sysctl_regs_chk u_chk (
    .clk(clk), .por(por), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .unlocked(lock_open),
    .rst_req(rst_req), .flags(flags_q), .nvflags(nvflags_q), .mux_sel(mux_sel)
);

// File: tb/sysctl_regs_test.sv
`timescale 1ns/1ps
module sysctl_regs_test;
    logic        clk = 1'b0;
    logic        por = 1'b1;
    logic        rst = 1'b0;
    logic        bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        card_in = 1'b0;
    logic        wp_in = 1'b0;
    logic [31:0] rd_a, rd_b, rd_x;
    logic        req_a, req_b, req_x;
    logic [1:0]  mux_a, mux_b, mux_x;
    int          n_checks = 0;
    int          n_fail = 0;

    always #4 clk = ~clk;

    // legacy board
    sysctl_regs #(.SYS_ID(32'h4100_5000)) uut (
        .clk(clk), .por(por), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(rd_a), .card_in(card_in), .wp_in(wp_in),
        .rst_req(req_a), .mux_sel(mux_a));
    // plus board
    sysctl_regs #(.SYS_ID(32'h4182_0000)) uut_b (
        .clk(clk), .por(por), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(rd_b), .card_in(card_in), .wp_in(wp_in),
        .rst_req(req_b), .mux_sel(mux_b));
    // express board
    sysctl_regs #(.SYS_ID(32'h4190_0000)) uut_x (
        .clk(clk), .por(por), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(rd_x), .card_in(card_in), .wp_in(wp_in),
        .rst_req(req_x), .mux_sel(mux_x));

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic at(input logic [11:0] a);
        bus_addr = a;
        #1;
    endtask

    task automatic soft_reset();
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
    endtask

    task automatic t_reset_state();
        at(12'h000); chk("R1 id legacy", rd_a, 32'h4100_5000);
        chk("R1 id express", rd_x, 32'h4190_0000);
        at(12'h044); chk("R1 const one", rd_a, 32'h1);
        at(12'h008); chk("R8 led reset", rd_a, 32'h0);
        at(12'h020); chk("R3 lock reset", rd_a, 32'h0);
        at(12'h050); chk("R9 disp reset legacy", rd_a, 32'h1F00);
        chk("R9 disp reset express", rd_x, 32'h0);
        chk("R10 mux reset", {30'h0, mux_a}, 32'h0);
    endtask

    task automatic t_led_unmapped();
        wr(12'h008, 32'hDEAD_0C3C);
        at(12'h008); chk("R2 led readback", rd_a, 32'hDEAD_0C3C);
        wr(12'h100, 32'hFFFF_FFFF);
        at(12'h100); chk("R1 unmapped reads zero", rd_a, 32'h0);
        at(12'h008); chk("R1 unmapped write ignored", rd_a, 32'hDEAD_0C3C);
    endtask

    task automatic t_lock_reset();
        wr(12'h020, 32'h0000_FFFF);
        at(12'h020); chk("R3 masked lock", rd_a, 32'h7FFF);
        wr(12'h040, 32'h0000_0104);
        chk("R4 no req while locked a", {31'h0, req_a}, 32'h0);
        chk("R4 no req while locked b", {31'h0, req_b}, 32'h0);
        at(12'h040); chk("R4 locked write ignored", rd_a, 32'h0);
        wr(12'h020, 32'h0000_A05F);
        at(12'h020); chk("R3 key stored", rd_a, 32'hA05F);
        wr(12'h040, 32'h0000_0100);
        chk("R5 legacy bit8 req", {31'h0, req_a}, 32'h1);
        chk("R5 plus ignores bit8", {31'h0, req_b}, 32'h0);
        chk("R5 express no req", {31'h0, req_x}, 32'h0);
        @(negedge clk);
        chk("R5 pulse one cycle", {31'h0, req_a}, 32'h0);
        at(12'h040); chk("R4 level stored legacy", rd_a, 32'h100);
        chk("R4 level stored plus", rd_b, 32'h100);
        chk("R4 express reads zero", rd_x, 32'h0);
        wr(12'h040, 32'h0000_0004);
        chk("R5 plus bit2 req", {31'h0, req_b}, 32'h1);
        chk("R5 legacy ignores bit2", {31'h0, req_a}, 32'h0);
        wr(12'h020, 32'h1234_A05F);
        at(12'h020); chk("R3 upper bits break key", rd_a, 32'h205F);
        wr(12'h040, 32'h0000_0100);
        chk("R4 relocked no req", {31'h0, req_a}, 32'h0);
        at(12'h040); chk("R4 relocked level kept", rd_a, 32'h4);
    endtask

    task automatic t_flags();
        wr(12'h030, 32'h0000_00F0);
        wr(12'h030, 32'h0000_0101);
        at(12'h030); chk("R6 set accumulates", rd_a, 32'h1F1);
        wr(12'h034, 32'h0000_0011);
        at(12'h030); chk("R6 clear bits", rd_a, 32'h1E0);
        at(12'h034); chk("R1 clear addr reads zero", rd_a, 32'h0);
        wr(12'h038, 32'h0000_00A5);
        wr(12'h03C, 32'h0000_0005);
        at(12'h038); chk("R7 nv set clear", rd_a, 32'hA0);
    endtask

    task automatic t_display();
        wr(12'h050, 32'hFFFF_FFFF);
        at(12'h050); chk("R9 legacy ro field", rd_a, 32'hFFFF_DFFF);
        chk("R9 plus bit7 only", rd_b, 32'h1F80);
        chk("R9 express raz", rd_x, 32'h0);
        chk("R10 legacy mux", {30'h0, mux_a}, 32'h3);
        chk("R10 plus no mux", {30'h0, mux_b}, 32'h0);
        wr(12'h050, 32'h0000_0002);
        at(12'h050); chk("R9 legacy rewrite", rd_a, 32'h1F02);
        chk("R10 legacy mux 2", {30'h0, mux_a}, 32'h2);
    endtask

    task automatic t_soft_reset();
        wr(12'h008, 32'h0000_003C);
        wr(12'h020, 32'h0000_A05F);
        soft_reset();
        at(12'h008); chk("R8 led cleared", rd_a, 32'h0);
        at(12'h020); chk("R8 lock cleared", rd_a, 32'h0);
        at(12'h030); chk("R8 flags cleared", rd_a, 32'h0);
        at(12'h040); chk("R8 level cleared", rd_a, 32'h0);
        at(12'h050); chk("R8 disp back to reset", rd_a, 32'h1F00);
        chk("R8 mux cleared", {30'h0, mux_a}, 32'h0);
        at(12'h038); chk("R7 nv survives soft reset", rd_a, 32'hA0);
    endtask

    task automatic t_card();
        @(negedge clk); card_in = 1'b1; wp_in = 1'b0;
        @(negedge clk);
        at(12'h048); chk("R11 card legacy", rd_a, 32'h1);
        chk("R11 card plus", rd_b, 32'h1);
        @(negedge clk); card_in = 1'b0; wp_in = 1'b1;
        @(negedge clk);
        at(12'h048); chk("R11 wp legacy bit2", rd_a, 32'h4);
        chk("R11 wp plus bit1", rd_b, 32'h2);
    endtask

    task automatic t_tick();
        logic [31:0] t0;
        @(negedge clk);
        at(12'h05C); t0 = rd_a;
        repeat (125) @(negedge clk);
        #1;
        chk("R12 tick delta", rd_a - t0, 32'd24);
        repeat (250) @(negedge clk);
        #1;
        chk("R12 tick delta long", rd_a - t0, 32'd72);
    endtask

    task automatic t_por();
        @(negedge clk); por = 1'b1;
        @(negedge clk); por = 1'b0;
        at(12'h038); chk("R7 por clears nv", rd_a, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        por = 1'b0;
        t_reset_state();
        t_led_unmapped();
        t_lock_reset();
        t_flags();
        t_display();
        t_soft_reset();
        t_card();
        t_tick();
        t_por();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule